// File: doc/BRIEF.md
# DMA Channel-Link Trigger Generator

This block belongs to a single DMA channel. It watches the channel's progress strobes and turns them into request pulses toward other channels, so that one channel's activity can start another channel's work without software. A beat-completion strobe can re-trigger a first partner channel after every single-beat (cycle-steal) transfer. The strobe that marks the remaining byte count reaching zero can trigger either the first partner or a second partner once per transfer.

Configuration consists of a 2-bit link mode and two partner indices. The output is a vector with one bit per channel in the controller. Each pulse lasts one clock cycle and at most one bit is high in any cycle. Deciding between channels that were triggered, and moving the data, are handled elsewhere.

Top module: `link_trigger_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `link_req` is all zeros.
- R2: With `link_mode` = 2'b00 no bit of `link_req` is ever set.
- R3: With `link_mode` = 2'b01, a `beat_done` strobe taken in cycle-steal mode without `count_zero` sets bit `link_a_idx` of `link_req`.
- R4: With `link_mode` = 2'b01, a `count_zero` strobe sets bit `link_b_idx` only. A beat strobe in the same cycle produces no pulse toward `link_a_idx`.
- R5: With `link_mode` = 2'b10, every cycle-steal beat, the final one included, pulses `link_a_idx`. A `count_zero` strobe without a beat produces nothing.
- R6: With `link_mode` = 2'b11, only `count_zero` produces a pulse, toward `link_a_idx`. Beats alone produce nothing.
- R7: When `steal_mode` is low, `beat_done` produces no pulse in any mode. Count-zero links are unaffected.
- R8: A partner index equal to `SELF_ID`, or not below `NUM_CH`, produces no pulse.
- R9: Pulses are registered. A pulse appears in the cycle after the strobe, lasts exactly one cycle unless a new strobe follows, and at most one bit of `link_req` is high at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_mode | input | 2 | Link mode: 00 off, 01 beat-to-A plus end-to-B, 10 beat-to-A, 11 end-to-A |
| link_a_idx | input | IDX_W | First partner channel index |
| link_b_idx | input | IDX_W | Second partner channel index |
| beat_done | input | 1 | One read/write beat of this channel completed |
| count_zero | input | 1 | Remaining byte count reached zero (final beat) |
| steal_mode | input | 1 | Channel runs one beat per request |
| link_req | output | NUM_CH | One-hot request pulses toward partner channels |

## Verification
The checker assumes that the strobes and configuration are sampled only at the clock edge. It also assumes that the configuration may change in any cycle, because each output depends only on the inputs of the cycle before. The properties tie each output cycle to the inputs of the previous cycle. They do not require the strobes to be single-cycle, and they do not require `count_zero` to coincide with `beat_done`. The directed stimulus drives each mode through idle beats, final beats and lone count-zero strobes, with both valid and invalid partner indices. A random phase then changes every input on every cycle, which keeps within those assumptions and still reaches back-to-back strobes.

// File: rtl/link_trig_pkg.sv
package link_trig_pkg;

  typedef enum logic [1:0] {
    LINK_OFF          = 2'b00,
    LINK_BEAT_AND_END = 2'b01,
    LINK_BEAT_ONLY    = 2'b10,
    LINK_END_ONLY     = 2'b11
  } link_mode_e;

  // A partner index is honoured only when it names another existing channel.
  function automatic logic idx_usable(input int unsigned idx,
                                      input int unsigned self_id,
                                      input int unsigned num_ch);
    return (idx < num_ch) && (idx != self_id);
  endfunction

endpackage

// File: rtl/link_event_decode.sv
module link_event_decode
  import link_trig_pkg::*;
(
  input  link_mode_e mode,
  input  logic       beat_done,
  input  logic       count_zero,
  input  logic       steal_mode,
  output logic       beat_evt,
  output logic       end_evt,
  output logic       want_a,
  output logic       want_b
);

  // Per-beat linking exists only in cycle-steal operation.
  assign beat_evt = beat_done & steal_mode;
  assign end_evt  = count_zero;

  always_comb begin
    want_a = 1'b0;
    want_b = 1'b0;
    case (mode)
      LINK_BEAT_AND_END: begin
        // The final beat hands over to the second partner only.
        want_b = end_evt;
        want_a = beat_evt & ~end_evt;
      end
      LINK_BEAT_ONLY: want_a = beat_evt;
      LINK_END_ONLY:  want_a = end_evt;
      default: begin
        want_a = 1'b0;
        want_b = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/link_target_decode.sv
module link_target_decode
  import link_trig_pkg::*;
#(
  parameter int NUM_CH  = 6,
  parameter int IDX_W   = 3,
  parameter int SELF_ID = 2
) (
  input  logic [IDX_W-1:0]  idx,
  output logic              usable,
  output logic [NUM_CH-1:0] onehot
);

  assign usable = idx_usable(32'(idx), SELF_ID, NUM_CH);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_bit
    assign onehot[c] = usable && (32'(idx) == c);
  end

endmodule

// File: rtl/link_trigger_gen.sv
module link_trigger_gen
  import link_trig_pkg::*;
#(
  parameter int NUM_CH  = 6,
  parameter int IDX_W   = 3,
  parameter int SELF_ID = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        link_mode,
  input  logic [IDX_W-1:0]  link_a_idx,
  input  logic [IDX_W-1:0]  link_b_idx,
  input  logic              beat_done,
  input  logic              count_zero,
  input  logic              steal_mode,
  output logic [NUM_CH-1:0] link_req
);

  localparam logic [NUM_CH-1:0] NO_REQ = '0;

  logic              beat_evt;
  logic              end_evt;
  logic              want_a;
  logic              want_b;
  logic              a_usable;
  logic              b_usable;
  logic [NUM_CH-1:0] hot_a;
  logic [NUM_CH-1:0] hot_b;
  logic [NUM_CH-1:0] req_next;

  link_event_decode u_evt (
    .mode       (link_mode_e'(link_mode)),
    .beat_done  (beat_done),
    .count_zero (count_zero),
    .steal_mode (steal_mode),
    .beat_evt   (beat_evt),
    .end_evt    (end_evt),
    .want_a     (want_a),
    .want_b     (want_b)
  );

  link_target_decode #(.NUM_CH(NUM_CH), .IDX_W(IDX_W), .SELF_ID(SELF_ID)) u_tgt_a (
    .idx    (link_a_idx),
    .usable (a_usable),
    .onehot (hot_a)
  );

  link_target_decode #(.NUM_CH(NUM_CH), .IDX_W(IDX_W), .SELF_ID(SELF_ID)) u_tgt_b (
    .idx    (link_b_idx),
    .usable (b_usable),
    .onehot (hot_b)
  );

  // want_a and want_b never coincide, so the OR stays one-hot.
  assign req_next = (want_a && a_usable ? hot_a : NO_REQ)
                  | (want_b && b_usable ? hot_b : NO_REQ);

  always_ff @(posedge clk) begin
    if (!rst_n) link_req <= NO_REQ;
    else        link_req <= req_next;
  end

endmodule

// File: rtl/link_trigger_chk.sv
module link_trigger_chk #(
  parameter int NUM_CH  = 6,
  parameter int IDX_W   = 3,
  parameter int SELF_ID = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        link_mode,
  input logic [IDX_W-1:0]  link_a_idx,
  input logic [IDX_W-1:0]  link_b_idx,
  input logic              beat_done,
  input logic              count_zero,
  input logic              steal_mode,
  input logic              beat_evt,
  input logic [NUM_CH-1:0] link_req
);

  function automatic logic ok_idx(input logic [IDX_W-1:0] i);
    return (32'(i) < NUM_CH) && (32'(i) != SELF_ID);
  endfunction

  function automatic logic [NUM_CH-1:0] bit_of(input logic [IDX_W-1:0] i);
    return ok_idx(i) ? (NUM_CH'(1) << i) : '0;
  endfunction

  p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> link_req == '0);

  p_mode_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    link_mode == 2'b00 |=> link_req == '0);

  p_beat_to_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (link_mode == 2'b01 && beat_done && steal_mode && !count_zero)
      |=> link_req == bit_of($past(link_a_idx)));

  p_end_to_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (link_mode == 2'b01 && count_zero) |=> link_req == bit_of($past(link_b_idx)));

  p_lone_end_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (link_mode == 2'b10 && count_zero && !beat_done) |=> link_req == '0);

  p_beat_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (link_mode == 2'b11 && !count_zero) |=> link_req == '0);

  p_no_steal_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat_evt && !count_zero) |=> link_req == '0);

  p_never_self_r8: assert property (@(posedge clk) disable iff (!rst_n)
    link_req[SELF_ID] == 1'b0);

  p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(link_req));

  p_pulse_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|link_req) |-> $past(beat_done || count_zero));

endmodule

bind link_trigger_gen link_trigger_chk #(
  .NUM_CH(NUM_CH), .IDX_W(IDX_W), .SELF_ID(SELF_ID)
) u_link_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .link_mode  (link_mode),
  .link_a_idx (link_a_idx),
  .link_b_idx (link_b_idx),
  .beat_done  (beat_done),
  .count_zero (count_zero),
  .steal_mode (steal_mode),
  .beat_evt   (beat_evt),
  .link_req   (link_req)
);

// File: tb/test_link_trigger_gen.sv
`timescale 1ns/1ps
module test_link_trigger_gen;

  localparam int NUM_CH  = 6;
  localparam int IDX_W   = 3;
  localparam int SELF_ID = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        link_mode = 2'b00;
  logic [IDX_W-1:0]  link_a_idx = '0;
  logic [IDX_W-1:0]  link_b_idx = '0;
  logic              beat_done = 1'b0;
  logic              count_zero = 1'b0;
  logic              steal_mode = 1'b0;
  logic [NUM_CH-1:0] link_req;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  link_trigger_gen #(.NUM_CH(NUM_CH), .IDX_W(IDX_W), .SELF_ID(SELF_ID)) i_link_trigger_gen (
    .clk(clk), .rst_n(rst_n), .link_mode(link_mode),
    .link_a_idx(link_a_idx), .link_b_idx(link_b_idx),
    .beat_done(beat_done), .count_zero(count_zero), .steal_mode(steal_mode),
    .link_req(link_req)
  );

  // Behavioural reference: which channel number the requirements say to hit.
  function automatic int target_of(int mode, int a, int b, bit beat, bit cz, bit steal);
    int t = -1;
    bit stolen = beat && steal;
    if (mode == 1)      t = cz ? b : (stolen ? a : -1);
    else if (mode == 2) t = stolen ? a : -1;
    else if (mode == 3) t = cz ? a : -1;
    if (t >= NUM_CH || t == SELF_ID) t = -1;
    return t;
  endfunction

  task automatic compare(input logic [NUM_CH-1:0] exp, input string req);
    n_cmp++;
    if (link_req !== exp) begin
      n_bad++;
      $display("FAIL %s: link_req=%b expected=%b at %0t", req, link_req, exp, $time);
    end
  endtask

  // Apply one cycle of inputs, then check the registered result.
  task automatic step(input int mode, input int a, input int b,
                      input bit beat, input bit cz, input bit steal, input string req);
    int t;
    logic [NUM_CH-1:0] exp;
    link_mode  = 2'(mode);
    link_a_idx = IDX_W'(a);
    link_b_idx = IDX_W'(b);
    beat_done  = beat;
    count_zero = cz;
    steal_mode = steal;
    t = target_of(mode, a, b, beat, cz, steal);
    exp = '0;
    if (t >= 0) exp[t] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    compare(exp, req);
  endtask

  task automatic idle(input string req);
    step(int'(link_mode), int'(link_a_idx), int'(link_b_idx), 1'b0, 1'b0, 1'b0, req);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: held in reset with strobes active
    link_mode = 2'b01; link_a_idx = 3'd4; beat_done = 1'b1; steal_mode = 1'b1;
    repeat (3) @(negedge clk);
    compare('0, "R1");
    beat_done = 1'b0;
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    compare('0, "R1");

    // R2: mode off ignores everything
    step(0, 4, 1, 1, 0, 1, "R2");
    step(0, 4, 1, 1, 1, 1, "R2");
    step(0, 4, 1, 0, 1, 0, "R2");

    // R3/R4: mode 01
    step(1, 4, 1, 1, 0, 1, "R3");
    step(1, 4, 1, 1, 0, 1, "R3");
    idle("R9");
    step(1, 4, 1, 1, 1, 1, "R4");
    step(1, 4, 1, 0, 1, 0, "R4");
    step(1, 5, 0, 1, 0, 1, "R3");
    idle("R9");

    // R5: mode 10
    step(2, 3, 1, 1, 0, 1, "R5");
    step(2, 3, 1, 1, 1, 1, "R5");
    step(2, 3, 1, 0, 1, 1, "R5");

    // R6: mode 11
    step(3, 0, 5, 1, 0, 1, "R6");
    step(3, 0, 5, 0, 1, 0, "R6");
    step(3, 0, 5, 1, 1, 1, "R6");

    // R7: no cycle steal
    step(1, 4, 1, 1, 0, 0, "R7");
    step(2, 4, 1, 1, 0, 0, "R7");
    step(1, 4, 1, 1, 1, 0, "R7");

    // R8: self and out-of-range partners
    step(2, SELF_ID, 1, 1, 0, 1, "R8");
    step(2, 6, 1, 1, 0, 1, "R8");
    step(1, 4, 7, 1, 1, 1, "R8");
    step(3, SELF_ID, 0, 0, 1, 0, "R8");

    // R9: back-to-back strobes and random traffic
    for (int i = 0; i < 400; i++) begin
      step(int'($urandom_range(3)), int'($urandom_range(7)), int'($urandom_range(7)),
           1'($urandom), 1'($urandom), 1'($urandom), "R9");
    end
    idle("R9");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule